// File: doc/BRIEF.md
# Multicycle Instruction Cycle Controller

This block is the control and register core of a small accumulator machine. It steps through the fetch, indirect, execute and interrupt subcycles. It reaches a single-port synchronous memory only through a memory address register (MAR) and a memory buffer register (MBR). The block holds the program counter, the opcode register, the accumulator and an interrupt-enable flag. A program is placed in memory and the reset is released. The block then runs the program until it meets a halt instruction.

Every subcycle is a short sequence of register transfers. A fetch copies the program counter into MAR, strobes a read and advances the program counter. It then takes the returned word into MBR, passes the opcode to the opcode register and passes the address field to MAR. An indirect operand costs one more read, and the word returned by that read becomes the effective address. The pending request is tested only when an instruction has finished. If the request is taken, the block writes the program counter to a fixed save word, clears the enable flag and continues at a fixed handler address.

Top module: `icyc_ctrl`

## Requirements
- R1: While reset is held, `mem_rd`, `mem_wr` and `halted` are low. After reset the program counter and the interrupt enable are zero, so the first memory access is a read of address 0.
- R2: An instruction word has the opcode in bits 15:12, the indirect flag in bit 11 and the address field in bits 10:0. Instructions run in address order. Opcode 0 halts, 1 loads, 2 stores, 3 adds, 4 jumps, 5 skips on zero, 6 enables interrupts and 7 returns from interrupt. Opcodes 8 to 15 change neither the accumulator nor memory.
- R3: Load copies the addressed word into the accumulator. Add adds the addressed word to the accumulator modulo 2^16. Store writes the accumulator to the addressed word.
- R4: When bit 11 is set on a load, store, add or jump, the word at the address field is read first, and its bits 10:0 (upper bits ignored) become the effective address.
- R5: Jump continues execution at the effective address. Skip-on-zero passes over the next instruction when the accumulator is zero, and has no effect otherwise.
- R6: Each read strobe lasts one cycle, and the data appears on `mem_rdata` in the following cycle. Each write strobe lasts one cycle. The two strobes are never high together.
- R7: When `irq` is high with interrupts enabled, the current instruction completes first. The block then writes the address of the next instruction to the save word `SAVE_ADDR` and continues at `HANDLER_ADDR`.
- R8: Interrupt entry and reset clear the enable. While it is clear, `irq` is ignored. Opcode 6 sets the enable.
- R9: Return-from-interrupt reloads the program counter from bits 10:0 of the save word and sets the enable.
- R10: After a halt, `halted` stays high and no memory strobe occurs until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq | input | 1 | Interrupt request, level sensitive |
| mem_rdata | input | 16 | Read data, valid the cycle after a read strobe |
| mem_addr | output | 11 | Memory address (MAR) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data (MBR) |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The hardest case to reach is a second interrupt that arrives while the handler of the first is still running. It must wait for the enable that the return restores, and the saved address must then be the one after the interrupted store. The bench models the memory. It raises `irq` when it sees the fetch read of chosen program addresses, and drops it when it sees the fetch of the return instruction. This leaves `irq` high across the handler's own store. The bench also counts writes to the save word, so it can tell a missing second entry apart from an extra one taken inside the handler.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_HALT  = 4'd0;
  localparam logic [OP_W-1:0] OP_LOAD  = 4'd1;
  localparam logic [OP_W-1:0] OP_STORE = 4'd2;
  localparam logic [OP_W-1:0] OP_ADD   = 4'd3;
  localparam logic [OP_W-1:0] OP_JUMP  = 4'd4;
  localparam logic [OP_W-1:0] OP_SKZ   = 4'd5;
  localparam logic [OP_W-1:0] OP_EINT  = 4'd6;
  localparam logic [OP_W-1:0] OP_RETI  = 4'd7;

  typedef enum logic [3:0] {
    S_F0, S_F1, S_F2, S_F3,
    S_I1, S_I2, S_I3,
    S_E0, S_E1, S_E2, S_E3,
    S_N0, S_N1, S_HALT
  } state_t;

  typedef enum logic [1:0] {MAR_PC, MAR_FIELD, MAR_SAVE} mar_sel_t;
  typedef enum logic [1:0] {MBR_RDATA, MBR_ACC, MBR_PC} mbr_sel_t;
  typedef enum logic [1:0] {PC_INC, PC_FIELD, PC_HANDLER, PC_RESTORE} pc_sel_t;
  typedef enum logic       {ACC_LOAD, ACC_ADD} acc_sel_t;

  typedef struct packed {
    logic     mar_en;
    mar_sel_t mar_sel;
    logic     mbr_en;
    mbr_sel_t mbr_sel;
    logic     ir_en;
    logic     pc_en;
    pc_sel_t  pc_sel;
    logic     acc_en;
    acc_sel_t acc_sel;
    logic     ie_set;
    logic     ie_clr;
    logic     rd;
    logic     wr;
    logic     halt;
  } ctl_t;

  function automatic logic uses_operand(input logic [OP_W-1:0] op);
    return (op == OP_LOAD) || (op == OP_STORE) || (op == OP_ADD) || (op == OP_JUMP);
  endfunction

endpackage

// File: rtl/icyc_rst_sync.sv
module icyc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q[i] <= 1'b0;
        else         q[i] <= 1'b1;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q[i] <= 1'b0;
        else         q[i] <= q[i-1];
      end
    end
  end

  assign srst_n = q[STAGES-1];

endmodule

// File: rtl/icyc_fsm.sv
module icyc_fsm
  import icyc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] ir_op,
  input  logic [OP_W-1:0] mbr_op,
  input  logic            mbr_ind,
  input  logic            acc_zero,
  input  logic            irq,
  input  logic            ie,
  output ctl_t            ctl
);

  state_t state, state_nx;
  state_t boundary;

  // instruction boundary: the only place a request is tested
  assign boundary = (irq && ie) ? S_N0 : S_F0;

  always_comb begin
    ctl      = '0;
    state_nx = state;
    unique case (state)
      S_F0: begin ctl.mar_en = 1'b1; ctl.mar_sel = MAR_PC; state_nx = S_F1; end
      S_F1: begin ctl.rd = 1'b1; ctl.pc_en = 1'b1; ctl.pc_sel = PC_INC; state_nx = S_F2; end
      S_F2: begin ctl.mbr_en = 1'b1; ctl.mbr_sel = MBR_RDATA; state_nx = S_F3; end
      S_F3: begin
        ctl.ir_en   = 1'b1;
        ctl.mar_en  = 1'b1;
        ctl.mar_sel = MAR_FIELD;
        state_nx    = (mbr_ind && uses_operand(mbr_op)) ? S_I1 : S_E0;
      end
      S_I1: begin ctl.rd = 1'b1; state_nx = S_I2; end
      S_I2: begin ctl.mbr_en = 1'b1; ctl.mbr_sel = MBR_RDATA; state_nx = S_I3; end
      S_I3: begin ctl.mar_en = 1'b1; ctl.mar_sel = MAR_FIELD; state_nx = S_E0; end
      S_E0: begin
        state_nx = boundary;
        case (ir_op)
          OP_LOAD, OP_ADD: begin ctl.rd = 1'b1; state_nx = S_E1; end
          OP_STORE: begin ctl.mbr_en = 1'b1; ctl.mbr_sel = MBR_ACC; state_nx = S_E1; end
          OP_JUMP:  begin ctl.pc_en = 1'b1; ctl.pc_sel = PC_FIELD; end
          OP_SKZ:   begin ctl.pc_en = acc_zero; ctl.pc_sel = PC_INC; end
          OP_EINT:  ctl.ie_set = 1'b1;
          OP_RETI:  begin ctl.mar_en = 1'b1; ctl.mar_sel = MAR_SAVE; state_nx = S_E1; end
          OP_HALT:  state_nx = S_HALT;
          default:  ;
        endcase
      end
      S_E1: begin
        state_nx = boundary;
        case (ir_op)
          OP_LOAD, OP_ADD: begin ctl.mbr_en = 1'b1; ctl.mbr_sel = MBR_RDATA; state_nx = S_E2; end
          OP_STORE: ctl.wr = 1'b1;
          OP_RETI:  begin ctl.rd = 1'b1; state_nx = S_E2; end
          default:  ;
        endcase
      end
      S_E2: begin
        state_nx = boundary;
        case (ir_op)
          OP_LOAD: begin ctl.acc_en = 1'b1; ctl.acc_sel = ACC_LOAD; end
          OP_ADD:  begin ctl.acc_en = 1'b1; ctl.acc_sel = ACC_ADD; end
          OP_RETI: begin ctl.mbr_en = 1'b1; ctl.mbr_sel = MBR_RDATA; state_nx = S_E3; end
          default: ;
        endcase
      end
      S_E3: begin
        ctl.pc_en  = 1'b1;
        ctl.pc_sel = PC_RESTORE;
        ctl.ie_set = 1'b1;
        state_nx   = boundary;
      end
      S_N0: begin
        ctl.mbr_en  = 1'b1;
        ctl.mbr_sel = MBR_PC;
        ctl.mar_en  = 1'b1;
        ctl.mar_sel = MAR_SAVE;
        state_nx    = S_N1;
      end
      S_N1: begin
        ctl.wr     = 1'b1;
        ctl.pc_en  = 1'b1;
        ctl.pc_sel = PC_HANDLER;
        ctl.ie_clr = 1'b1;
        state_nx   = S_F0;
      end
      S_HALT: ctl.halt = 1'b1;
      default: state_nx = S_F0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_F0;
    else        state <= state_nx;
  end

endmodule

// File: rtl/icyc_dp.sv
module icyc_dp
  import icyc_pkg::*;
#(
  parameter int          WORD_W       = 16,
  parameter int          ADDR_W       = 11,
  parameter logic [10:0] SAVE_ADDR    = 11'h7F0,
  parameter logic [10:0] HANDLER_ADDR = 11'h040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [OP_W-1:0]   ir_op,
  output logic [OP_W-1:0]   mbr_op,
  output logic              mbr_ind,
  output logic              acc_zero,
  output logic              ie
);

  localparam int OP_LSB  = WORD_W - OP_W;
  localparam int IND_BIT = OP_LSB - 1;
  localparam int PAD_W   = WORD_W - ADDR_W;

  logic [ADDR_W-1:0] pc, pc_d, mar, mar_d;
  logic [WORD_W-1:0] mbr, mbr_d, acc, acc_d;
  logic [OP_W-1:0]   ir;

  always_comb begin
    unique case (ctl.mar_sel)
      MAR_PC:    mar_d = pc;
      MAR_FIELD: mar_d = mbr[ADDR_W-1:0];
      default:   mar_d = SAVE_ADDR[ADDR_W-1:0];
    endcase
    unique case (ctl.mbr_sel)
      MBR_RDATA: mbr_d = mem_rdata;
      MBR_ACC:   mbr_d = acc;
      default:   mbr_d = {{PAD_W{1'b0}}, pc};
    endcase
    unique case (ctl.pc_sel)
      PC_INC:     pc_d = pc + 1'b1;
      PC_FIELD:   pc_d = mar;
      PC_HANDLER: pc_d = HANDLER_ADDR[ADDR_W-1:0];
      default:    pc_d = mbr[ADDR_W-1:0];
    endcase
    acc_d = (ctl.acc_sel == ACC_ADD) ? acc + mbr : mbr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= '0;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      acc <= '0;
      ie  <= 1'b0;
    end else begin
      if (ctl.pc_en)  pc  <= pc_d;
      if (ctl.mar_en) mar <= mar_d;
      if (ctl.mbr_en) mbr <= mbr_d;
      if (ctl.ir_en)  ir  <= mbr[WORD_W-1:OP_LSB];
      if (ctl.acc_en) acc <= acc_d;
      if (ctl.ie_clr)      ie <= 1'b0;
      else if (ctl.ie_set) ie <= 1'b1;
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign ir_op     = ir;
  assign mbr_op    = mbr[WORD_W-1:OP_LSB];
  assign mbr_ind   = mbr[IND_BIT];
  assign acc_zero  = (acc == '0);

endmodule

// File: rtl/icyc_ctrl.sv
module icyc_ctrl
  import icyc_pkg::*;
#(
  parameter int          WORD_W       = 16,
  parameter int          ADDR_W       = 11,
  parameter int          SYNC_STAGES  = 2,
  parameter logic [10:0] SAVE_ADDR    = 11'h7F0,
  parameter logic [10:0] HANDLER_ADDR = 11'h040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              halted
);

  logic            rst_core_n;
  ctl_t            ctl;
  logic [OP_W-1:0] ir_op, mbr_op;
  logic            mbr_ind, acc_zero, int_en;

  icyc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_core_n)
  );

  icyc_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .ir_op    (ir_op),
    .mbr_op   (mbr_op),
    .mbr_ind  (mbr_ind),
    .acc_zero (acc_zero),
    .irq      (irq),
    .ie       (int_en),
    .ctl      (ctl)
  );

  icyc_dp #(
    .WORD_W       (WORD_W),
    .ADDR_W       (ADDR_W),
    .SAVE_ADDR    (SAVE_ADDR),
    .HANDLER_ADDR (HANDLER_ADDR)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .ctl       (ctl),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .ir_op     (ir_op),
    .mbr_op    (mbr_op),
    .mbr_ind   (mbr_ind),
    .acc_zero  (acc_zero),
    .ie        (int_en)
  );

  assign mem_rd = ctl.rd;
  assign mem_wr = ctl.wr;
  assign halted = ctl.halt;

endmodule

// File: rtl/icyc_ctrl_chk.sv
module icyc_ctrl_chk #(
  parameter int          ADDR_W    = 11,
  parameter logic [10:0] SAVE_ADDR = 11'h7F0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              halted,
  input logic              ie
);

  // R6
  rdwr_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R6
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  // R6
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd && !mem_wr));

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R7
  entry_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ie) |-> $past(mem_wr && (mem_addr == SAVE_ADDR[ADDR_W-1:0])));

endmodule

bind icyc_ctrl icyc_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .SAVE_ADDR (SAVE_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .mem_addr (mem_addr),
  .halted   (halted),
  .ie       (int_en)
);

// File: tb/icyc_ctrl_bench.sv
`timescale 1ns/1ps
module icyc_ctrl_bench;

  localparam int          WW   = 16;
  localparam int          AW   = 11;
  localparam int          MEMN = 1 << AW;
  localparam logic [10:0] SAVE = 11'h7F0;
  localparam logic [10:0] HND  = 11'h040;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          irq = 1'b0;
  logic [WW-1:0] mem_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr;
  logic [WW-1:0] mem_wdata;
  logic          halted;

  logic [WW-1:0] mem [0:MEMN-1];
  int            checks = 0;
  int            fails  = 0;
  logic          cnt_clr = 1'b1;
  int            save_cnt;
  logic [WW-1:0] save_first;

  always #2.5 clk = ~clk;

  icyc_ctrl u_icyc_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .halted    (halted)
  );

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (cnt_clr) save_cnt <= 0;
    else if (mem_wr && mem_addr == SAVE) begin
      if (save_cnt == 0) save_first <= mem_wdata;
      save_cnt <= save_cnt + 1;
    end
  end

  function automatic logic [WW-1:0] ins(input logic [3:0] op, input logic ind, input logic [10:0] a);
    return {op, ind, a};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold_reset();
    rst_n   = 1'b0;
    irq     = 1'b0;
    cnt_clr = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < MEMN; i++) mem[i] = '0;
  endtask

  task automatic release_reset();
    rst_n   = 1'b1;
    cnt_clr = 1'b0;
  endtask

  task automatic run_halt(input string req);
    int cyc = 0;
    while (!halted && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    chk(halted, req, {31'd0, halted}, 32'd1);
  endtask

  // vector: {indirect, a, b}; program sums a+b into word 302
  localparam logic [32:0] VECS [0:5] = '{
    {1'b0, 16'd5,     16'd9},
    {1'b0, 16'hFFFF,  16'h0002},
    {1'b1, 16'h1234,  16'h0F0F},
    {1'b1, 16'h8000,  16'h8000},
    {1'b0, 16'h0000,  16'h0000},
    {1'b1, 16'h7FFF,  16'h0001}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    logic [WW-1:0] exp;
    int            guard;

    // R1: reset state, including release from a halted state later
    hold_reset();
    chk(!mem_rd && !mem_wr, "R1 strobes in reset", {30'd0, mem_rd, mem_wr}, 32'd0);
    chk(!halted, "R1 halted in reset", {31'd0, halted}, 32'd0);
    mem[0] = ins(4'd0, 1'b0, 11'd0);
    release_reset();
    guard = 0;
    while (!mem_rd && !mem_wr && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    chk(mem_rd && mem_addr == 0, "R1 first access is read of 0", {21'd0, mem_addr}, 32'd0);

    // R2 R3 R4: vector table
    for (int k = 0; k < 6; k++) begin
      logic          ind;
      logic [WW-1:0] a, b;
      {ind, a, b} = VECS[k];
      hold_reset();
      mem[0] = ins(4'd1, ind, ind ? 11'd100 : 11'd300);
      mem[1] = ins(4'd3, ind, ind ? 11'd101 : 11'd301);
      mem[2] = ins(4'd2, ind, ind ? 11'd102 : 11'd302);
      mem[3] = ins(4'd0, 1'b0, 11'd0);
      mem[100] = 16'hF800 | 16'd300;
      mem[101] = 16'hF800 | 16'd301;
      mem[102] = 16'hF800 | 16'd302;
      mem[300] = a;
      mem[301] = b;
      release_reset();
      run_halt("R2 program halts");
      exp = a + b;
      chk(mem[302] == exp, ind ? "R4 indirect sum" : "R3 direct sum", {16'd0, mem[302]}, {16'd0, exp});
    end

    // R5: jump over a store
    hold_reset();
    mem[0]  = ins(4'd4, 1'b0, 11'd20);
    mem[1]  = ins(4'd2, 1'b0, 11'd312);
    mem[2]  = ins(4'd0, 1'b0, 11'd0);
    mem[20] = ins(4'd1, 1'b0, 11'd313);
    mem[21] = ins(4'd2, 1'b0, 11'd314);
    mem[22] = ins(4'd0, 1'b0, 11'd0);
    mem[312] = 16'hAAAA;
    mem[313] = 16'h0033;
    release_reset();
    run_halt("R5 jump halts");
    chk(mem[314] == 16'h0033, "R5 jump target ran", {16'd0, mem[314]}, 32'h33);
    chk(mem[312] == 16'hAAAA, "R5 jumped-over store", {16'd0, mem[312]}, 32'hAAAA);

    // R5: skip-on-zero, both outcomes
    for (int z = 0; z < 2; z++) begin
      hold_reset();
      mem[0] = ins(4'd1, 1'b0, 11'd310);
      mem[1] = ins(4'd5, 1'b0, 11'd0);
      mem[2] = ins(4'd2, 1'b0, 11'd311);
      mem[3] = ins(4'd0, 1'b0, 11'd0);
      mem[310] = (z == 0) ? 16'd0 : 16'd4;
      mem[311] = 16'hAAAA;
      release_reset();
      run_halt("R5 skip halts");
      exp = (z == 0) ? 16'hAAAA : 16'd4;
      chk(mem[311] == exp, "R5 skip on zero", {16'd0, mem[311]}, {16'd0, exp});
    end

    // R2: unassigned opcode leaves accumulator and memory alone
    hold_reset();
    mem[0] = ins(4'd1, 1'b0, 11'd320);
    mem[1] = ins(4'd9, 1'b1, 11'd322);
    mem[2] = ins(4'd2, 1'b0, 11'd321);
    mem[3] = ins(4'd0, 1'b0, 11'd0);
    mem[320] = 16'h0777;
    mem[322] = 16'h5555;
    release_reset();
    run_halt("R2 no-op halts");
    chk(mem[321] == 16'h0777, "R2 no-op keeps accumulator", {16'd0, mem[321]}, 32'h777);
    chk(mem[322] == 16'h5555, "R2 no-op keeps memory", {16'd0, mem[322]}, 32'h5555);

    // R7 R8 R9: two interrupts, irq held through the handler store
    hold_reset();
    mem[0] = ins(4'd6, 1'b0, 11'd0);
    mem[1] = ins(4'd1, 1'b0, 11'd400);
    mem[2] = ins(4'd3, 1'b0, 11'd401);
    mem[3] = ins(4'd2, 1'b0, 11'd402);
    mem[4] = ins(4'd0, 1'b0, 11'd0);
    mem[HND]     = ins(4'd2, 1'b0, 11'd411);
    mem[HND + 1] = ins(4'd7, 1'b0, 11'd0);
    mem[400] = 16'd7;
    mem[401] = 16'd5;
    release_reset();
    guard = 0;
    while (!halted && guard < 3000) begin
      @(negedge clk);
      guard++;
      if (mem_rd && (mem_addr == 1 || mem_addr == 3)) irq = 1'b1;
      if (mem_rd && mem_addr == HND + 1) irq = 1'b0;
    end
    chk(halted, "R9 interrupted program halts", {31'd0, halted}, 32'd1);
    chk(save_first == 16'd2, "R7 first saved address", {16'd0, save_first}, 32'd2);
    chk(mem[SAVE] == 16'd4, "R9 enable restored, second save", {16'd0, mem[SAVE]}, 32'd4);
    chk(mem[411] == 16'd12, "R7 handler sees completed add", {16'd0, mem[411]}, 32'd12);
    chk(mem[402] == 16'd12, "R9 resumed program result", {16'd0, mem[402]}, 32'd12);
    chk(save_cnt == 2, "R8 no entry inside handler", save_cnt, 32'd2);

    // R8: enable clear after reset, irq held high throughout
    hold_reset();
    mem[0] = ins(4'd1, 1'b0, 11'd400);
    mem[1] = ins(4'd2, 1'b0, 11'd402);
    mem[2] = ins(4'd0, 1'b0, 11'd0);
    mem[400] = 16'd7;
    irq = 1'b1;
    release_reset();
    run_halt("R8 disabled run halts");
    chk(save_cnt == 0, "R8 irq ignored while disabled", save_cnt, 32'd0);
    chk(mem[402] == 16'd7, "R8 program unaffected", {16'd0, mem[402]}, 32'd7);
    irq = 1'b0;

    // R10: quiet after halt
    guard = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (mem_rd || mem_wr || !halted) guard++;
    end
    chk(guard == 0, "R10 quiet and halted", guard, 32'd0);
    hold_reset();
    chk(!halted, "R1 reset clears halt", {31'd0, halted}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule